// File: doc/BRIEF.md
# Register-Access Command Packer

This block turns a short list of register accesses into the payload and command word of a mailbox transfer. A requester presents up to a fixed number of entries in one handshake. Each entry has a 16-bit register address, and write-type operations also carry data bytes. The block arranges the entries into a byte buffer and streams that buffer out as 32-bit little-endian words at byte offsets 0, 4, 8 and so on. It then emits a command word that gives the message type, the operation and the packed byte count. For every word it drives the byte offset, and a flag separates the command word from payload words.

Two packing arrangements are available, chosen by a mode input. In interleaved mode each entry's bytes stay together. In grouped mode all addresses come first and the data follows them. After the command word the block waits for the mailbox to report completion. It then returns the error bit it received and, for reads, the response bytes taken from the mailbox read buffer at mode-dependent positions. Requests the transfer format cannot carry are refused on the spot with an error pulse.

Top module: `reg_cmd_packer`

## Requirements
- R1: After reset `reqReady` is 1 and `wrValid`, `rspValid` and `rejectPulse` are 0.
- R2: The command word carries 0xFF in bits [7:0], zero in bits [11:8], the operation code in bits [15:12], the packed byte count in bits [23:16] and zero in bits [31:24]. Operation codes are write = 0, read = 1, read-modify-write = 2.
- R3: With `reqMode` = 1 (interleaved), each entry i in order adds address bits [7:0], then address bits [15:8]. A write then adds one data byte `reqData` byte i. A read-modify-write adds a value byte (`reqData` byte 0) and then a mask byte (`reqData` byte 1). The size field equals the number of bytes packed.
- R4: With `reqMode` = 0 (grouped), the address pairs of all entries sit at bytes 2i and 2i+1. A write then places data byte i at byte 2·count+i, and the size is 3·count. A read has size 2·count. A read-modify-write places the value at byte 2 and the mask at byte 3, and the size is 4.
- R5: Payload words go out on consecutive cycles with `wrIsCmd` = 0, at byte offsets 0, 4, 8, and so on. There are ceil(size/4) of them, each little-endian, and bytes past the size read as zero. The command word, with `wrIsCmd` = 1, follows in the next cycle.
- R6: A request is refused if its count is 0 or above MAX_ENTRIES, if its operation code is 3, or if it is a read-modify-write with a count other than 1. A refused request raises `rejectPulse` for the one cycle after acceptance, emits no word, and leaves `reqReady` at 1.
- R7: After the command word, `rspValid` stays 0 until `doneIn` is seen. It is then 1 for exactly one cycle, in the cycle after `doneIn`, with `rspErr` equal to the `doneErr` sampled with it.
- R8: For a read, result byte i (of every one of MAX_ENTRIES slots) is read-buffer byte 2+3i in interleaved mode and read-buffer byte i in grouped mode. For other operations all result bytes are zero.
- R9: From the cycle after an accepted request until the cycle carrying `rspValid`, `reqReady` is 0, and any request offered in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqOp | input | 2 | Operation code: 0 write, 1 read, 2 read-modify-write |
| reqMode | input | 1 | 1 interleaved packing, 0 grouped packing |
| reqCount | input | CNT_W (3) | Number of entries |
| reqAddr | input | MAX_ENTRIES*16 (80) | Entry addresses, entry i in bits [16i+15:16i] |
| reqData | input | MAX_ENTRIES*8 (40) | Data bytes, byte i in bits [8i+7:8i] |
| rejectPulse | output | 1 | Request refused |
| wrValid | output | 1 | A word is presented to the mailbox |
| wrIsCmd | output | 1 | The presented word is the command word |
| wrOffset | output | OFF_W (5) | Byte offset of a payload word |
| wrData | output | 32 | Word value |
| doneIn | input | 1 | Mailbox reports completion |
| doneErr | input | 1 | Error bit that comes with completion |
| rspBuf | input | RBUF_BYTES*8 (128) | Mailbox read buffer, byte k in bits [8k+7:8k] |
| rspValid | output | 1 | Result available |
| rspErr | output | 1 | Completion error bit |
| rspData | output | MAX_ENTRIES*8 (40) | Result bytes, slot i in bits [8i+7:8i] |

## Verification
The bench builds the block with its defaults: five entries and a 16-byte read buffer. With these values the largest grouped write fills 15 bytes over four words. A five-entry interleaved read draws from read-buffer byte 14, so the highest stride position lies inside the buffer. Counts of 6 and 7 fit in the count port, which puts the over-limit refusal within reach together with the zero-count, reserved-code and multi-entry read-modify-write refusals.

// File: rtl/reg_cmd_packer_pkg.sv
package reg_cmd_packer_pkg;

  localparam logic [7:0] MSG_TYPE = 8'hFF;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_RMW   = 2'd2;

  localparam logic MODE_GROUPED     = 1'b0;
  localparam logic MODE_INTERLEAVED = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic emitWord;
    logic emitCmd;
    logic capture;
  } pkCtrl_t;

endpackage

// File: rtl/reg_cmd_packer_ctrl.sv
module reg_cmd_packer_ctrl
  import reg_cmd_packer_pkg::*;
#(
  parameter int MAX_ENTRIES = 5,
  parameter int CNT_W = 3,
  parameter int WIDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [7:0]        sizeQ,
  input  logic              doneIn,
  output logic              reqReady,
  output logic              rejectPulse,
  output logic              rspValid,
  output logic [WIDX_W-1:0] wordIdx,
  output pkCtrl_t           ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_CMD, ST_WAIT} state_t;

  state_t state;
  logic accept;
  logic badReq;
  logic [7:0] wordsM1;

  always_comb begin
    reqReady = (state == ST_IDLE);
    accept   = reqValid && reqReady;
    badReq   = (reqCount == '0) ||
               (int'(reqCount) > MAX_ENTRIES) ||
               (reqOp == 2'd3) ||
               ((reqOp == OP_RMW) && (reqCount != CNT_W'(1)));
    ctrl          = '0;
    ctrl.load     = accept && !badReq;
    ctrl.emitWord = (state == ST_EMIT);
    ctrl.emitCmd  = (state == ST_CMD);
    ctrl.capture  = (state == ST_WAIT) && doneIn;
    wordsM1       = ((sizeQ + 8'd3) >> 2) - 8'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wordIdx     <= '0;
      rejectPulse <= 1'b0;
      rspValid    <= 1'b0;
    end else begin
      rejectPulse <= accept && badReq;
      rspValid    <= ctrl.capture;
      case (state)
        ST_IDLE: begin
          if (ctrl.load) begin
            state   <= ST_EMIT;
            wordIdx <= '0;
          end
        end
        ST_EMIT: begin
          if (8'(wordIdx) == wordsM1) state <= ST_CMD;
          else wordIdx <= wordIdx + WIDX_W'(1);
        end
        ST_CMD:  state <= ST_WAIT;
        ST_WAIT: if (doneIn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reg_cmd_packer_dp.sv
module reg_cmd_packer_dp
  import reg_cmd_packer_pkg::*;
#(
  parameter int MAX_ENTRIES = 5,
  parameter int RBUF_BYTES = 16,
  parameter int CNT_W = 3,
  parameter int WIDX_W = 3,
  localparam int BUF_BYTES = MAX_ENTRIES * 4,
  localparam int BYTE_IDX_W = $clog2(BUF_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pkCtrl_t                  ctrl,
  input  logic [1:0]               reqOp,
  input  logic                     reqMode,
  input  logic [CNT_W-1:0]         reqCount,
  input  logic [MAX_ENTRIES*16-1:0] reqAddr,
  input  logic [MAX_ENTRIES*8-1:0] reqData,
  input  logic [WIDX_W-1:0]        wordIdx,
  input  logic [RBUF_BYTES*8-1:0]  rspBuf,
  input  logic                     doneErr,
  output logic [7:0]               sizeQ,
  output logic [31:0]              outWord,
  output logic                     rspErr,
  output logic [MAX_ENTRIES*8-1:0] rspData
);

  logic [BUF_BYTES-1:0][7:0] packBuf;
  logic [BUF_BYTES-1:0][7:0] bufQ;
  logic [7:0] packSize;
  logic [7:0] ptr;
  logic [7:0] gIdx;
  logic [1:0] opQ;
  logic       modeQ;

  // byte serializer for both arrangements
  always_comb begin
    packBuf  = '0;
    ptr      = '0;
    gIdx     = '0;
    for (int i = 0; i < MAX_ENTRIES; i++) begin
      if (i < int'(reqCount)) begin
        if (reqMode == MODE_INTERLEAVED) begin
          if (int'(ptr) < BUF_BYTES) packBuf[ptr[BYTE_IDX_W-1:0]] = reqAddr[16*i +: 8];
          ptr = ptr + 8'd1;
          if (int'(ptr) < BUF_BYTES) packBuf[ptr[BYTE_IDX_W-1:0]] = reqAddr[16*i+8 +: 8];
          ptr = ptr + 8'd1;
          if (reqOp == OP_WRITE) begin
            if (int'(ptr) < BUF_BYTES) packBuf[ptr[BYTE_IDX_W-1:0]] = reqData[8*i +: 8];
            ptr = ptr + 8'd1;
          end else if (reqOp == OP_RMW) begin
            if (int'(ptr) < BUF_BYTES) packBuf[ptr[BYTE_IDX_W-1:0]] = reqData[7:0];
            ptr = ptr + 8'd1;
            if (int'(ptr) < BUF_BYTES) packBuf[ptr[BYTE_IDX_W-1:0]] = reqData[15:8];
            ptr = ptr + 8'd1;
          end
        end else begin
          packBuf[BYTE_IDX_W'(2*i)]   = reqAddr[16*i +: 8];
          packBuf[BYTE_IDX_W'(2*i+1)] = reqAddr[16*i+8 +: 8];
          if (reqOp == OP_WRITE) begin
            gIdx = 8'(2 * int'(reqCount) + i);
            if (int'(gIdx) < BUF_BYTES) packBuf[gIdx[BYTE_IDX_W-1:0]] = reqData[8*i +: 8];
          end
        end
      end
    end
    if ((reqMode == MODE_GROUPED) && (reqOp == OP_RMW)) begin
      packBuf[BYTE_IDX_W'(2)] = reqData[7:0];
      packBuf[BYTE_IDX_W'(3)] = reqData[15:8];
    end
    if (reqMode == MODE_INTERLEAVED) packSize = ptr;
    else if (reqOp == OP_WRITE)      packSize = 8'(3 * int'(reqCount));
    else if (reqOp == OP_READ)       packSize = 8'(2 * int'(reqCount));
    else                             packSize = 8'd4;
  end

  // response byte selection, one lane per result slot
  logic [MAX_ENTRIES-1:0][7:0] ilByte;
  logic [MAX_ENTRIES-1:0][7:0] grByte;

  for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_lane
    localparam int IL_POS = 2 + 3 * g;
    if (IL_POS < RBUF_BYTES) begin : g_il
      assign ilByte[g] = rspBuf[IL_POS*8 +: 8];
    end else begin : g_il_none
      assign ilByte[g] = '0;
    end
    if (g < RBUF_BYTES) begin : g_gr
      assign grByte[g] = rspBuf[g*8 +: 8];
    end else begin : g_gr_none
      assign grByte[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ    <= '0;
      sizeQ   <= '0;
      opQ     <= '0;
      modeQ   <= 1'b0;
      rspErr  <= 1'b0;
      rspData <= '0;
    end else begin
      if (ctrl.load) begin
        bufQ  <= packBuf;
        sizeQ <= packSize;
        opQ   <= reqOp;
        modeQ <= reqMode;
      end
      if (ctrl.capture) begin
        rspErr <= doneErr;
        for (int i = 0; i < MAX_ENTRIES; i++) begin
          if (opQ != OP_READ)               rspData[8*i +: 8] <= '0;
          else if (modeQ == MODE_INTERLEAVED) rspData[8*i +: 8] <= ilByte[i];
          else                              rspData[8*i +: 8] <= grByte[i];
        end
      end
    end
  end

  // word emitter and command word
  always_comb begin
    if (ctrl.emitCmd)       outWord = {8'h00, sizeQ, 2'b00, opQ, 4'h0, MSG_TYPE};
    else if (ctrl.emitWord) outWord = bufQ[int'(wordIdx)*4 +: 4];
    else                    outWord = '0;
  end

endmodule

// File: rtl/reg_cmd_packer.sv
module reg_cmd_packer
  import reg_cmd_packer_pkg::*;
#(
  parameter int MAX_ENTRIES = 5,
  parameter int RBUF_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int WIDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int OFF_W = WIDX_W + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [1:0]                reqOp,
  input  logic                      reqMode,
  input  logic [CNT_W-1:0]          reqCount,
  input  logic [MAX_ENTRIES*16-1:0] reqAddr,
  input  logic [MAX_ENTRIES*8-1:0]  reqData,
  output logic                      rejectPulse,
  output logic                      wrValid,
  output logic                      wrIsCmd,
  output logic [OFF_W-1:0]          wrOffset,
  output logic [31:0]               wrData,
  input  logic                      doneIn,
  input  logic                      doneErr,
  input  logic [RBUF_BYTES*8-1:0]   rspBuf,
  output logic                      rspValid,
  output logic                      rspErr,
  output logic [MAX_ENTRIES*8-1:0]  rspData
);

  pkCtrl_t ctrl;
  logic [WIDX_W-1:0] wordIdx;
  logic [7:0] sizeQ;

  reg_cmd_packer_ctrl #(
    .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .WIDX_W(WIDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqCount(reqCount), .sizeQ(sizeQ), .doneIn(doneIn),
    .reqReady(reqReady), .rejectPulse(rejectPulse), .rspValid(rspValid),
    .wordIdx(wordIdx), .ctrl(ctrl)
  );

  reg_cmd_packer_dp #(
    .MAX_ENTRIES(MAX_ENTRIES), .RBUF_BYTES(RBUF_BYTES),
    .CNT_W(CNT_W), .WIDX_W(WIDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqOp(reqOp), .reqMode(reqMode),
    .reqCount(reqCount), .reqAddr(reqAddr), .reqData(reqData),
    .wordIdx(wordIdx), .rspBuf(rspBuf), .doneErr(doneErr),
    .sizeQ(sizeQ), .outWord(wrData), .rspErr(rspErr), .rspData(rspData)
  );

  assign wrValid  = ctrl.emitWord | ctrl.emitCmd;
  assign wrIsCmd  = ctrl.emitCmd;
  assign wrOffset = ctrl.emitWord ? {wordIdx, 2'b00} : '0;

endmodule

// File: rtl/reg_cmd_packer_chk.sv
module reg_cmd_packer_chk #(
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rejectPulse,
  input logic             wrValid,
  input logic             wrIsCmd,
  input logic [OFF_W-1:0] wrOffset,
  input logic [31:0]      wrData,
  input logic             doneIn,
  input logic             rspValid
);

  // R2
  cmd_layout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrIsCmd) |-> (wrData[7:0] == 8'hFF && wrData[11:8] == 4'h0 &&
                              wrData[31:24] == 8'h00));

  // R5
  word_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrIsCmd) |=> wrValid);

  // R5
  word_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrIsCmd) |=> (wrIsCmd || wrOffset == $past(wrOffset) + OFF_W'(4)));

  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> (!wrValid && reqReady));

  // R7
  rsp_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(doneIn));

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !reqReady);

endmodule

bind reg_cmd_packer reg_cmd_packer_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rejectPulse(rejectPulse),
  .wrValid(wrValid), .wrIsCmd(wrIsCmd), .wrOffset(wrOffset), .wrData(wrData),
  .doneIn(doneIn), .rspValid(rspValid)
);

// File: tb/reg_cmd_packer_bench.sv
module reg_cmd_packer_bench;

  localparam int NE = 5;
  localparam int RB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = '0;
  logic reqMode = 1'b0;
  logic [2:0] reqCount = '0;
  logic [NE*16-1:0] reqAddr = '0;
  logic [NE*8-1:0] reqData = '0;
  logic rejectPulse, wrValid, wrIsCmd;
  logic [4:0] wrOffset;
  logic [31:0] wrData;
  logic doneIn = 1'b0;
  logic doneErr = 1'b0;
  logic [RB*8-1:0] rspBuf = '0;
  logic rspValid, rspErr;
  logic [NE*8-1:0] rspData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  reg_cmd_packer u_reg_cmd_packer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqMode(reqMode), .reqCount(reqCount), .reqAddr(reqAddr),
    .reqData(reqData), .rejectPulse(rejectPulse), .wrValid(wrValid),
    .wrIsCmd(wrIsCmd), .wrOffset(wrOffset), .wrData(wrData), .doneIn(doneIn),
    .doneErr(doneErr), .rspBuf(rspBuf), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData)
  );

  // word monitor: records every presented word in the cycle before each edge
  int capTotal = 0;
  logic [31:0] capData [64];
  logic [4:0]  capOff [64];
  logic        capCmd [64];

  always @(posedge clk) begin
    if (wrValid) begin
      capData[capTotal % 64] <= wrData;
      capOff[capTotal % 64]  <= wrOffset;
      capCmd[capTotal % 64]  <= wrIsCmd;
      capTotal <= capTotal + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference arrangement built from R3/R4
  task automatic refPack(input logic [1:0] op, input logic mode, input int cnt,
                         input logic [NE*16-1:0] addr, input logic [NE*8-1:0] data,
                         output logic [7:0] buff [20], output int size);
    int p;
    for (int k = 0; k < 20; k++) buff[k] = 8'h00;
    p = 0;
    if (mode) begin
      for (int i = 0; i < cnt; i++) begin
        buff[p] = addr[16*i +: 8]; p++;
        buff[p] = addr[16*i+8 +: 8]; p++;
        if (op == 2'd0) begin buff[p] = data[8*i +: 8]; p++; end
        if (op == 2'd2) begin
          buff[p] = data[7:0]; p++;
          buff[p] = data[15:8]; p++;
        end
      end
      size = p;
    end else begin
      for (int i = 0; i < cnt; i++) begin
        buff[2*i]   = addr[16*i +: 8];
        buff[2*i+1] = addr[16*i+8 +: 8];
        if (op == 2'd0) buff[2*cnt+i] = data[8*i +: 8];
      end
      if (op == 2'd2) begin buff[2] = data[7:0]; buff[3] = data[15:8]; size = 4; end
      else if (op == 2'd0) size = 3 * cnt;
      else size = 2 * cnt;
    end
  endtask

  task automatic doXfer(input string name, input logic [1:0] op, input logic mode,
                        input int cnt, input logic [NE*16-1:0] addr,
                        input logic [NE*8-1:0] data, input logic err,
                        input bit poke);
    logic [7:0] buff [20];
    int size, nw, start, waitCnt;
    logic [31:0] expW, expCmd;
    logic [NE*8-1:0] expRsp;
    refPack(op, mode, cnt, addr, data, buff, size);
    nw = (size + 3) / 4;
    for (int k = 0; k < RB; k++) rspBuf[8*k +: 8] = 8'(8'h40 + 7 * k);
    @(negedge clk);
    start = capTotal;
    reqOp = op; reqMode = mode; reqCount = 3'(cnt); reqAddr = addr; reqData = data;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, {name, " R9 ready low after accept"}, 64'(reqReady), 0);
    if (poke) begin
      reqOp = 2'd1; reqMode = ~mode; reqCount = 3'd2; reqValid = 1'b1;
    end
    waitCnt = 0;
    while (capTotal - start < nw + 1 && waitCnt < 40) begin
      @(negedge clk);
      waitCnt++;
    end
    reqValid = 1'b0;
    chk(capTotal - start == nw + 1, {name, " R5 word count"}, 64'(capTotal - start), 64'(nw + 1));
    for (int w = 0; w < nw; w++) begin
      expW = {buff[4*w+3], buff[4*w+2], buff[4*w+1], buff[4*w]};
      chk(capData[(start+w)%64] == expW && capCmd[(start+w)%64] == 1'b0,
          {name, " R3/R4 R5 payload word"}, 64'(capData[(start+w)%64]), 64'(expW));
      chk(capOff[(start+w)%64] == 5'(4*w), {name, " R5 offset"},
          64'(capOff[(start+w)%64]), 64'(4*w));
    end
    expCmd = {8'h00, 8'(size), 2'b00, op, 4'h0, 8'hFF};
    chk(capData[(start+nw)%64] == expCmd && capCmd[(start+nw)%64] == 1'b1,
        {name, " R2 command word"}, 64'(capData[(start+nw)%64]), 64'(expCmd));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rspValid == 1'b0 && reqReady == 1'b0, {name, " R7 no result before done"},
          64'({rspValid, reqReady}), 0);
    end
    doneIn = 1'b1; doneErr = err;
    @(negedge clk);
    doneIn = 1'b0; doneErr = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (op != 2'd1) expRsp[8*i +: 8] = 8'h00;
      else if (mode) expRsp[8*i +: 8] = 8'(8'h40 + 7 * (2 + 3 * i));
      else expRsp[8*i +: 8] = 8'(8'h40 + 7 * i);
    end
    chk(rspValid == 1'b1 && rspErr == err, {name, " R7 result with error bit"},
        64'({rspValid, rspErr}), 64'({1'b1, err}));
    chk(rspData == expRsp, {name, " R8 result bytes"}, 64'(rspData), 64'(expRsp));
    @(negedge clk);
    chk(rspValid == 1'b0 && reqReady == 1'b1, {name, " R7 R9 single result pulse"},
        64'({rspValid, reqReady}), 64'(1));
    chk(capTotal - start == nw + 1, {name, " R9 no extra words"},
        64'(capTotal - start), 64'(nw + 1));
  endtask

  task automatic doReject(input string name, input logic [1:0] op, input int cnt);
    int start;
    @(negedge clk);
    start = capTotal;
    reqOp = op; reqMode = 1'b1; reqCount = 3'(cnt); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(rejectPulse == 1'b1 && reqReady == 1'b1, {name, " R6 reject pulse"},
        64'({rejectPulse, reqReady}), 64'(3));
    @(negedge clk);
    chk(rejectPulse == 1'b0, {name, " R6 pulse one cycle"}, 64'(rejectPulse), 0);
    repeat (4) @(negedge clk);
    chk(capTotal == start, {name, " R6 nothing emitted"}, 64'(capTotal - start), 0);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 1);
    chk(wrValid == 1'b0 && rspValid == 1'b0 && rejectPulse == 1'b0,
        "R1 outputs idle", 64'({wrValid, rspValid, rejectPulse}), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // interleaved
    doXfer("il_write3", 2'd0, 1'b1, 3, 80'h0000_0000_ABCD_0056_1234, 40'h00_00_33_22_11, 1'b0, 1'b0);
    doXfer("il_read5", 2'd1, 1'b1, 5, 80'h0105_0104_0103_0102_0101, 40'h0, 1'b1, 1'b0);
    doXfer("il_rmw1", 2'd2, 1'b1, 1, 80'h0000_0000_0000_0000_00C7, 40'h00_00_00_0F_A5, 1'b0, 1'b0);
    doXfer("il_write5", 2'd0, 1'b1, 5, 80'hF0E0_D0C0_B0A0_9080_7060, 40'h55_44_33_22_11, 1'b0, 1'b0);
    // grouped
    doXfer("gr_write5", 2'd0, 1'b0, 5, 80'h2005_2004_2003_2002_2001, 40'hEE_DD_CC_BB_AA, 1'b0, 1'b0);
    doXfer("gr_read2", 2'd1, 1'b0, 2, 80'h0000_0000_0000_3344_1122, 40'h0, 1'b0, 1'b0);
    doXfer("gr_rmw1", 2'd2, 1'b0, 1, 80'h0000_0000_0000_0000_0F0E, 40'h00_00_00_F0_3C, 1'b1, 1'b0);
    doXfer("gr_read1", 2'd1, 1'b0, 1, 80'h0000_0000_0000_0000_8001, 40'h0, 1'b0, 1'b0);
    // busy: request offered while in flight is ignored
    doXfer("busy_write2", 2'd0, 1'b0, 2, 80'h0000_0000_0000_0202_0101, 40'h00_00_00_9A_89, 1'b0, 1'b1);
    // refusals
    doReject("count0", 2'd0, 0);
    doReject("count6", 2'd1, 6);
    doReject("count7", 2'd0, 7);
    doReject("rmw_count2", 2'd2, 2);
    doReject("op3", 2'd3, 1);
    // still works after refusals
    doXfer("after_reject", 2'd1, 1'b1, 2, 80'h0000_0000_0000_0A0B_0C0D, 40'h0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule